// File: doc/BRIEF.md
# Logical Channel Destination Table

This block sits in the send path of a core. An instruction that sends its result onto the on-chip network names a small logical channel number. The block turns that number into a full network destination and presents the result, with its destination, on a valid/ready output toward the network. The destination is held in a run-time writable table. A map-setting instruction loads an entry from a register value. Because of this, a thread's outputs can be moved to other consumers without changing any code.

An entry names one of two things. The first is a single channel-end: a tile, a core or memory bank within it, and a channel there. The second is a multicast set of cores inside the local tile, with one channel number, so that a single send reaches any subset of those cores. A unicast entry that points at another tile uses end-to-end flow control. Each entry keeps its own credit count, which starts at the receiver's buffer depth. A send uses one credit and a returned credit restores one. A send with no credit left is stalled. The stall output also covers a blocked network (ready low). The pipeline holds the instruction until the stall clears.

Top module: `chan_map_table`

## Requirements
- R1: After reset every entry holds address 0 (unicast, tile 0, component 0, channel 0) and every credit count equals CREDIT_DEPTH (4). With no send request, netValid and stall are both 0.
- R2: A table write is visible to a send in the following cycle. A send presents on netDest the entry selected by sendChan, and netData equals sendData.
- R3: An address has 12 bits. Bit 11 is the multicast flag. For unicast, bits 10:7 are the tile, bits 6:3 the component (0-7 a core, 8-15 a bank) and bits 2:0 the channel. netRemote is 1 exactly for a unicast entry whose tile differs from LOCAL_TILE (5).
- R4: A send to a remote entry fires (netValid and netReady) only while its credit count is non-zero, and each firing uses one credit. At zero credits, netValid is 0 and stall is 1.
- R5: A credit return (creditValid, creditIdx) adds one to that entry's count, up to a maximum of CREDIT_DEPTH. A firing send and a return on the same entry in one cycle leave the count unchanged.
- R6: While netReady is 0, a send with credit available shows netValid 1 and stall 1, and it uses no credit.
- R7: Multicast entries and local unicast entries never stall for credits. They stall only on netReady.
- R8: Writing an entry resets its credit count to CREDIT_DEPTH. This applies even when a send or a credit return hits the same entry in that cycle. A send in the same cycle as a write to its entry uses the old address.
- R9: netCoreMask gives the local cores reached. For multicast it is bits 10:3 of the address (bit n is core n). For local unicast to a core c it is a one-hot mask with bit c set. Otherwise it is 0.
- R10: A cycle without sendReq uses no credit and changes no table content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Map-setting write strobe |
| tblWrIdx | input | 4 | Entry to write |
| tblWrAddr | input | 12 | Network address to store |
| sendReq | input | 1 | Send request from the pipeline |
| sendChan | input | 4 | Logical channel of the send |
| sendData | input | 32 | Result being sent |
| netReady | input | 1 | Network accepts this cycle |
| netValid | output | 1 | Send presented to the network |
| netDest | output | 12 | Full destination address |
| netCoreMask | output | 8 | Local cores reached |
| netRemote | output | 1 | Destination lies in another tile |
| netData | output | 32 | Data toward the network |
| creditValid | input | 1 | Credit return strobe |
| creditIdx | input | 4 | Entry receiving the credit |
| stall | output | 1 | Hold the sending instruction |

## Verification
Random traffic mixes remote unicast, local unicast and multicast entries with random writes, credit returns and ready patterns. This separates credit-gated stalls from network stalls, and it checks that only remote entries consume credits. Directed runs exhaust an entry's credits, refill them past the limit to show saturation, and hold ready low to show that no credit leaks. Further directed runs combine a write with a send or a return on the same entry. These show that the old address is used and that the refill wins. Local core and bank targets then check the mask decode.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic sendFire;   // send accepted by the network this cycle
    logic tableWrite; // map-setting write
    logic creditRet;  // credit return arrives
  } cmtStrobe_t;
endpackage

// File: rtl/cmt_datapath.sv
module cmt_datapath
  import cmt_pkg::*;
#(
  parameter int ENTRIES      = 16,
  parameter int CORES        = 8,
  parameter int TILE_W       = 4,
  parameter int COMP_W       = 4,
  parameter int CHAN_W       = 3,
  parameter int CREDIT_DEPTH = 4,
  parameter int LOCAL_TILE   = 5,
  parameter int IDX_W        = $clog2(ENTRIES),
  parameter int FIELD_W      = (CORES > TILE_W + COMP_W) ? CORES : TILE_W + COMP_W,
  parameter int ADDR_W       = 1 + FIELD_W + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmtStrobe_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  retIdx,
  output logic [ADDR_W-1:0] rdEntry,
  output logic              rdCreditOk,
  output logic              rdNeedsCredit,
  output logic [CORES-1:0]  coreMask
);
  localparam int CNT_W = $clog2(CREDIT_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CREDIT_DEPTH);
  localparam int MC_BIT   = ADDR_W - 1;
  localparam int COMP_LSB = CHAN_W;
  localparam int TILE_LSB = CHAN_W + COMP_W;

  logic [ADDR_W-1:0] entryQ [ENTRIES];
  logic [CNT_W-1:0]  cntQ   [ENTRIES];

  // Decode of the entry selected by the send.
  logic              rdMcast;
  logic [TILE_W-1:0] rdTile;
  logic [COMP_W-1:0] rdComp;

  always_comb begin
    rdEntry       = entryQ[rdIdx];
    rdMcast       = rdEntry[MC_BIT];
    rdTile        = rdEntry[TILE_LSB +: TILE_W];
    rdComp        = rdEntry[COMP_LSB +: COMP_W];
    rdNeedsCredit = !rdMcast && (rdTile != TILE_W'(LOCAL_TILE));
    rdCreditOk    = (cntQ[rdIdx] != '0);
    coreMask      = '0;
    if (rdMcast) begin
      coreMask = rdEntry[COMP_LSB +: CORES];
    end else if (!rdNeedsCredit && (int'(rdComp) < CORES)) begin
      coreMask[rdComp[$clog2(CORES)-1:0]] = 1'b1;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic             wrHit, decHit, retHit;
    logic [CNT_W:0]   sumCnt;
    logic [CNT_W-1:0] nextCnt;

    always_comb begin
      wrHit   = strb.tableWrite && (wrIdx == IDX_W'(i));
      decHit  = strb.sendFire && rdNeedsCredit && (rdIdx == IDX_W'(i));
      retHit  = strb.creditRet && (retIdx == IDX_W'(i));
      sumCnt  = {1'b0, cntQ[i]} + (CNT_W+1)'(retHit) - (CNT_W+1)'(decHit);
      nextCnt = (sumCnt > {1'b0, FULL}) ? FULL : sumCnt[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ[i] <= '0;
        cntQ[i]   <= FULL;
      end else if (wrHit) begin
        entryQ[i] <= wrAddr;
        cntQ[i]   <= FULL;
      end else if (decHit || retHit) begin
        cntQ[i]   <= nextCnt;
      end
    end
  end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
  import cmt_pkg::*;
(
  input  logic       sendReq,
  input  logic       netReady,
  input  logic       tblWrEn,
  input  logic       creditValid,
  input  logic       rdCreditOk,
  input  logic       rdNeedsCredit,
  output logic       netValid,
  output logic       stall,
  output cmtStrobe_t strb
);
  logic mayGo;

  always_comb begin
    mayGo           = !rdNeedsCredit || rdCreditOk;
    netValid        = sendReq && mayGo;
    stall           = sendReq && !(netReady && mayGo);
    strb.sendFire   = netValid && netReady;
    strb.tableWrite = tblWrEn;
    strb.creditRet  = creditValid;
  end
endmodule

// File: rtl/chan_map_table.sv
module chan_map_table
  import cmt_pkg::*;
#(
  parameter int ENTRIES      = 16,
  parameter int CORES        = 8,
  parameter int TILE_W       = 4,
  parameter int COMP_W       = 4,
  parameter int CHAN_W       = 3,
  parameter int DATA_W       = 32,
  parameter int CREDIT_DEPTH = 4,
  parameter int LOCAL_TILE   = 5,
  parameter int IDX_W        = $clog2(ENTRIES),
  parameter int FIELD_W      = (CORES > TILE_W + COMP_W) ? CORES : TILE_W + COMP_W,
  parameter int ADDR_W       = 1 + FIELD_W + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic [ADDR_W-1:0] tblWrAddr,
  input  logic              sendReq,
  input  logic [IDX_W-1:0]  sendChan,
  input  logic [DATA_W-1:0] sendData,
  input  logic              netReady,
  output logic              netValid,
  output logic [ADDR_W-1:0] netDest,
  output logic [CORES-1:0]  netCoreMask,
  output logic              netRemote,
  output logic [DATA_W-1:0] netData,
  input  logic              creditValid,
  input  logic [IDX_W-1:0]  creditIdx,
  output logic              stall
);
  cmtStrobe_t strb;
  logic       rdCreditOk, rdNeedsCredit;

  cmt_ctrl uCtrl (
    .sendReq       (sendReq),
    .netReady      (netReady),
    .tblWrEn       (tblWrEn),
    .creditValid   (creditValid),
    .rdCreditOk    (rdCreditOk),
    .rdNeedsCredit (rdNeedsCredit),
    .netValid      (netValid),
    .stall         (stall),
    .strb          (strb)
  );

  cmt_datapath #(
    .ENTRIES      (ENTRIES),
    .CORES        (CORES),
    .TILE_W       (TILE_W),
    .COMP_W       (COMP_W),
    .CHAN_W       (CHAN_W),
    .CREDIT_DEPTH (CREDIT_DEPTH),
    .LOCAL_TILE   (LOCAL_TILE),
    .IDX_W        (IDX_W),
    .FIELD_W      (FIELD_W),
    .ADDR_W       (ADDR_W)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrIdx         (tblWrIdx),
    .wrAddr        (tblWrAddr),
    .rdIdx         (sendChan),
    .retIdx        (creditIdx),
    .rdEntry       (netDest),
    .rdCreditOk    (rdCreditOk),
    .rdNeedsCredit (rdNeedsCredit),
    .coreMask      (netCoreMask)
  );

  assign netRemote = rdNeedsCredit;
  assign netData   = sendData;
endmodule

// File: rtl/chan_map_table_chk.sv
module chan_map_table_chk #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 12,
  parameter int CORES  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tblWrEn,
  input logic [IDX_W-1:0]  tblWrIdx,
  input logic [ADDR_W-1:0] tblWrAddr,
  input logic              sendReq,
  input logic [IDX_W-1:0]  sendChan,
  input logic [DATA_W-1:0] sendData,
  input logic              netReady,
  input logic              netValid,
  input logic [ADDR_W-1:0] netDest,
  input logic [CORES-1:0]  netCoreMask,
  input logic              netRemote,
  input logic [DATA_W-1:0] netData,
  input logic              stall
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sendReq |-> (!netValid && !stall));

  a_r6_blocked_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !netReady) |-> stall);

  a_r2_data_through: assert property (@(posedge clk) disable iff (!rstN)
    netValid |-> (netData == sendData));

  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn ##1 (sendReq && sendChan == $past(tblWrIdx)) |-> (netDest == $past(tblWrAddr)));

  a_r8_rewrite_refills: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn ##1 (sendReq && netReady && sendChan == $past(tblWrIdx)) |-> !stall);

  a_r7_mcast_no_credit: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && netDest[ADDR_W-1]) |-> netValid);

  a_r9_unicast_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !netDest[ADDR_W-1]) |-> $onehot0(netCoreMask));

  a_r3_remote_no_mask: assert property (@(posedge clk) disable iff (!rstN)
    netRemote |-> (netCoreMask == '0));
endmodule

bind chan_map_table chan_map_table_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CORES(CORES), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
  .tblWrAddr(tblWrAddr), .sendReq(sendReq), .sendChan(sendChan),
  .sendData(sendData), .netReady(netReady), .netValid(netValid),
  .netDest(netDest), .netCoreMask(netCoreMask), .netRemote(netRemote),
  .netData(netData), .stall(stall)
);

// File: tb/tb_chan_map_table.sv
`timescale 1ns/1ps
module tb_chan_map_table;
  localparam int LOCAL = 5;
  localparam int DEPTH = 4;

  logic        clk = 0;
  logic        rstN = 0;
  logic        tblWrEn = 0;
  logic [3:0]  tblWrIdx = 0;
  logic [11:0] tblWrAddr = 0;
  logic        sendReq = 0;
  logic [3:0]  sendChan = 0;
  logic [31:0] sendData = 0;
  logic        netReady = 0;
  logic        netValid;
  logic [11:0] netDest;
  logic [7:0]  netCoreMask;
  logic        netRemote;
  logic [31:0] netData;
  logic        creditValid = 0;
  logic [3:0]  creditIdx = 0;
  logic        stall;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [11:0] refEntry [16];
  int          refCnt   [16];

  always #5 clk = ~clk;

  chan_map_table dut (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrAddr(tblWrAddr), .sendReq(sendReq), .sendChan(sendChan),
    .sendData(sendData), .netReady(netReady), .netValid(netValid),
    .netDest(netDest), .netCoreMask(netCoreMask), .netRemote(netRemote),
    .netData(netData), .creditValid(creditValid), .creditIdx(creditIdx),
    .stall(stall)
  );

  function automatic logic expRemote(logic [11:0] a);
    return !a[11] && (a[10:7] != 4'(LOCAL));
  endfunction

  function automatic logic [7:0] expMask(logic [11:0] a);
    if (a[11]) return a[10:3];
    if (!expRemote(a) && a[6:3] < 8) return 8'(1) << a[6:3];
    return 8'h00;
  endfunction

  function automatic logic [11:0] uni(int tile, int comp, int ch);
    return {1'b0, 4'(tile), 4'(comp), 3'(ch)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare combinational outputs, advance model at posedge.
  task automatic step(string tag, bit we, int wi, logic [11:0] wa,
                      bit sr, int sc, bit rdy, bit cv, int ci);
    logic [11:0] e;
    bit ok, fire, rem;
    @(negedge clk);
    tblWrEn = we; tblWrIdx = 4'(wi); tblWrAddr = wa;
    sendReq = sr; sendChan = 4'(sc); sendData = $urandom; netReady = rdy;
    creditValid = cv; creditIdx = 4'(ci);
    #1;
    e    = refEntry[sc];
    rem  = expRemote(e);
    ok   = !rem || refCnt[sc] != 0;
    fire = sr && ok && rdy;
    chk(tag, "netValid", 32'(netValid), 32'(sr && ok));
    chk(tag, "stall", 32'(stall), 32'(sr && !(rdy && ok)));
    if (sr) begin
      chk(tag, "netDest", 32'(netDest), 32'(e));
      chk(tag, "netRemote", 32'(netRemote), 32'(rem));
      chk(tag, "netCoreMask", 32'(netCoreMask), 32'(expMask(e)));
    end
    if (netValid) chk(tag, "netData", netData, sendData);
    for (int i = 0; i < 16; i++) begin
      int n;
      n = refCnt[i] + ((cv && ci == i) ? 1 : 0) - ((fire && rem && sc == i) ? 1 : 0);
      if (n > DEPTH) n = DEPTH;
      if (we && wi == i) begin
        refEntry[i] = wa;
        n = DEPTH;
      end
      refCnt[i] = n;
    end
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) begin refEntry[i] = '0; refCnt[i] = DEPTH; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset contents and idle outputs
    step("R1", 0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 16; i++) step("R1", 0, 0, 0, 1, i, 0, 0, 0);

    // R2, R3: write remote entry, visible next cycle
    step("R2", 1, 2, uni(3, 1, 2), 0, 0, 1, 0, 0);
    step("R3", 0, 0, 0, 1, 2, 0, 0, 0);

    // R4: exhaust credits, then stall
    for (int k = 0; k < 6; k++) step("R4", 0, 0, 0, 1, 2, 1, 0, 0);

    // R5: returns beyond depth saturate; send and return together keep count
    for (int k = 0; k < 7; k++) step("R5", 0, 0, 0, 0, 0, 1, 1, 2);
    for (int k = 0; k < 3; k++) step("R5", 0, 0, 0, 1, 2, 1, 1, 2);
    for (int k = 0; k < 5; k++) step("R5", 0, 0, 0, 1, 2, 1, 0, 0);

    // R6: blocked network uses no credit
    step("R5", 0, 0, 0, 0, 0, 1, 1, 2);
    for (int k = 0; k < 5; k++) step("R6", 0, 0, 0, 1, 2, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 2, 1, 0, 0);
    step("R6", 0, 0, 0, 1, 2, 1, 0, 0);

    // R7, R9: multicast and local unicast never credit-stall
    step("R9", 1, 5, {1'b1, 8'hA5, 3'd4}, 0, 0, 1, 0, 0);
    for (int k = 0; k < 7; k++) step("R7", 0, 0, 0, 1, 5, 1, 0, 0);
    step("R9", 1, 6, uni(LOCAL, 3, 1), 0, 0, 1, 0, 0);
    for (int k = 0; k < 6; k++) step("R7", 0, 0, 0, 1, 6, 1, 0, 0);
    step("R9", 1, 7, uni(LOCAL, 10, 0), 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 1, 7, 1, 0, 0);

    // R8: write with send on same entry uses old mapping, then refill
    for (int k = 0; k < 4; k++) step("R8", 0, 0, 0, 1, 9, 1, 0, 0);
    step("R8", 1, 9, uni(1, 2, 3), 1, 9, 1, 1, 9);
    for (int k = 0; k < 5; k++) step("R8", 0, 0, 0, 1, 9, 1, 0, 0);

    // R10: no send leaves state alone
    for (int k = 0; k < 4; k++) step("R10", 0, 0, 0, 0, 9, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 9, 1, 0, 0);

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int kind;
      logic [11:0] a;
      kind = $urandom_range(0, 9);
      if (kind < 6)      a = uni($urandom_range(0, 15) == 5 ? 6 : $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7));
      else if (kind < 8) a = uni(LOCAL, $urandom_range(0, 15), $urandom_range(0, 7));
      else               a = {1'b1, 8'($urandom), 3'($urandom)};
      step("R2", ($urandom_range(0, 15) == 0), $urandom_range(0, 15), a,
           ($urandom_range(0, 3) != 0), $urandom_range(0, 15),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) == 0),
           $urandom_range(0, 15));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule